// File: doc/BRIEF.md
# Secondary-Core Boot Release Mailbox

This block holds the secondary processor cores of a multi-core cluster in a wait state until the primary core lets them go. The primary core sees four 32-bit fields through a simple register port with address, write data, write enable and registered read data. The fields are a start address, a go word, a ready word and a poll word. The mailbox window spans 0x80 bytes. Offsets from 0x10 upward are left for a code area that lives outside this block, so they read as zero here.

Every secondary core has a fixed 8-bit identity. A core is released when two things hold at once: a wake event has just occurred, and the go word equals the constant 0xABBAAB00 OR'ed with that core's identity. Any bus write to the go word broadcasts a one-cycle wake pulse, so the waiting cores compare again. A released core keeps its release level high while the go word still matches. It receives the start address that the start-address field held at the moment it was released. A reset request from any secondary core clears the go word, so no core leaves until software writes the go word again.

Top module: `boot_mailbox`

## Requirements
- R1: After the synchronous reset, all four fields read zero, `wake_evt` is low, every `core_release` bit is low and every `core_entry` word is zero.
- R2: A write to a field stores the full data word. The fields sit at byte offsets 0x0 (start address), 0x4 (go), 0x8 (ready) and 0xC (poll). `bus_addr[1:0]` is ignored. `bus_rdata` shows the addressed field one clock edge after the address is presented.
- R3: Reads at byte offsets 0x10 to 0x7F return zero. Writes there change no field and raise no wake.
- R4: Every bus write to the go word drives `wake_evt` high for exactly the one cycle after the write edge. Writes to other offsets leave it low.
- R5: Secondary core i has identity FIRST_ID+i (low 8 bits). With the defaults, the cores are identities 1, 2 and 3, with go values 0xABBAAB01, 0xABBAAB02 and 0xABBAAB03. After a go write, the release bit of exactly the core whose value matches rises on the edge after the wake cycle. No other release bit rises. A go value of 0xABBAAB00 releases none of these cores.
- R6: A release bit stays high while the go word keeps matching. It falls on the same edge as R5 once the go word is written with a non-matching value.
- R7: `core_entry` for core i is loaded from the start-address field on the edge where its release bit rises. It does not follow later writes to the start-address field.
- R8: A pulse on any `core_reset` bit clears the go word on that edge. This overrides a bus write to the go word in the same cycle. Every release bit then falls on the next edge. The reset pulse raises no wake by itself, although a concurrent go write still does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address within the mailbox window |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | DATA_W | Registered read data of the addressed field |
| core_reset | input | NUM_CORES | Per-secondary-core reset pulse; any bit clears the go word |
| wake_evt | output | 1 | One-cycle wake broadcast after a go-word write |
| core_release | output | NUM_CORES | Per-core release level |
| core_entry | output | NUM_CORES*DATA_W | Per-core start address, core i in bits [i*DATA_W +: DATA_W] |

## Verification
Each result is due at a fixed number of rising edges after the edge that samples the stimulus:
- Read data is due one edge after the address is presented.
- The wake pulse is due one edge after a go write and is gone one edge later.
- Release levels and start addresses settle two edges after a go write.
- A core reset clears the go word on its own edge, and the release bits fall one edge later.

The bench drives inputs on falling edges. It then checks each output on the falling edge that follows exactly the number of rising edges given above, using a field-and-release model updated inside the same tasks that drive the port.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int unsigned NUM_FIELDS = 4;

  typedef enum logic [1:0] {
    FLD_ENTRY = 2'd0,
    FLD_GO    = 2'd1,
    FLD_READY = 2'd2,
    FLD_POLL  = 2'd3
  } fld_e;

  localparam logic [31:0] GO_MAGIC = 32'hABBAAB00;

endpackage

// File: rtl/mbx_fields.sv
module mbx_fields
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              clr_go,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wake_evt,
  output logic [DATA_W-1:0] entry_val,
  output logic [DATA_W-1:0] go_val
);

  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] LAST_IDX = WORD_W'(NUM_FIELDS - 1);

  logic [DATA_W-1:0] fld_q [NUM_FIELDS];
  logic [DATA_W-1:0] rdata_q;
  logic              wake_q;
  logic [WORD_W-1:0] word_idx;
  logic              in_fields;
  logic [1:0]        fld_sel;
  logic              go_wr;

  assign word_idx  = bus_addr[ADDR_W-1:2];
  assign in_fields = (word_idx <= LAST_IDX);
  assign fld_sel   = word_idx[1:0];
  assign go_wr     = bus_we && in_fields && (fld_sel == FLD_GO);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_FIELDS; k++) fld_q[k] <= '0;
      rdata_q <= '0;
      wake_q  <= 1'b0;
    end else begin
      if (bus_we && in_fields) fld_q[fld_sel] <= bus_wdata;
      // a secondary-core reset wins over a same-cycle bus write to the go word
      if (clr_go) fld_q[FLD_GO] <= '0;
      rdata_q <= in_fields ? fld_q[fld_sel] : '0;
      wake_q  <= go_wr;
    end
  end

  assign bus_rdata = rdata_q;
  assign wake_evt  = wake_q;
  assign entry_val = fld_q[FLD_ENTRY];
  assign go_val    = fld_q[FLD_GO];

endmodule

// File: rtl/mbx_core_gate.sv
module mbx_core_gate
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter logic [7:0]  CORE_ID = 8'd1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wake,
  input  logic [DATA_W-1:0] go_val,
  input  logic [DATA_W-1:0] entry_val,
  output logic              release_o,
  output logic [DATA_W-1:0] start_o
);

  localparam logic [DATA_W-1:0] EXPECT_GO = DATA_W'(GO_MAGIC) | DATA_W'(CORE_ID);

  logic              rel_q;
  logic [DATA_W-1:0] start_q;
  logic              match;

  assign match = (go_val == EXPECT_GO);

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_q   <= 1'b0;
      start_q <= '0;
    end else if (rel_q) begin
      rel_q <= match;
    end else if (wake && match) begin
      rel_q   <= 1'b1;
      start_q <= entry_val;
    end
  end

  assign release_o = rel_q;
  assign start_o   = start_q;

endmodule

// File: rtl/boot_mailbox.sv
module boot_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_CORES = 3,
  parameter int unsigned FIRST_ID  = 1,
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  input  logic                        bus_we,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_CORES-1:0]        core_reset,
  output logic                        wake_evt,
  output logic [NUM_CORES-1:0]        core_release,
  output logic [NUM_CORES*DATA_W-1:0] core_entry
);

  logic [DATA_W-1:0] entry_val;
  logic [DATA_W-1:0] go_val;
  logic              clr_go;

  assign clr_go = |core_reset;

  mbx_fields #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) fields_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .clr_go    (clr_go),
    .bus_rdata (bus_rdata),
    .wake_evt  (wake_evt),
    .entry_val (entry_val),
    .go_val    (go_val)
  );

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    localparam int unsigned ID_FULL = FIRST_ID + g;
    mbx_core_gate #(
      .DATA_W  (DATA_W),
      .CORE_ID (8'(ID_FULL))
    ) gate_i (
      .clk       (clk),
      .rst       (rst),
      .wake      (wake_evt),
      .go_val    (go_val),
      .entry_val (entry_val),
      .release_o (core_release[g]),
      .start_o   (core_entry[g*DATA_W +: DATA_W])
    );
  end

endmodule

// File: rtl/boot_mailbox_chk.sv
module boot_mailbox_chk #(
  parameter int unsigned NUM_CORES = 3,
  parameter int unsigned ADDR_W    = 7,
  parameter int unsigned DATA_W    = 32
) (
  input logic                        clk,
  input logic                        rst,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic                        bus_we,
  input logic [NUM_CORES-1:0]        core_reset,
  input logic                        wake_evt,
  input logic [NUM_CORES-1:0]        core_release,
  input logic [NUM_CORES*DATA_W-1:0] core_entry
);

  logic go_wr;
  assign go_wr = bus_we && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!wake_evt && core_release == '0));

  // R4
  a_r4_wake_after_go_write: assert property (@(posedge clk) disable iff (rst)
    go_wr |=> wake_evt);

  // R4
  a_r4_wake_only_from_go_write: assert property (@(posedge clk) disable iff (rst)
    wake_evt |-> $past(go_wr && !rst));

  // R8
  a_r8_core_reset_drops_release: assert property (@(posedge clk) disable iff (rst)
    (|core_reset) |=> ##1 (core_release == '0));

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_chk
    // R5
    a_r5_release_rises_after_wake: assert property (@(posedge clk) disable iff (rst)
      $rose(core_release[g]) |-> $past(wake_evt));
    // R7
    a_r7_entry_held_while_released: assert property (@(posedge clk) disable iff (rst)
      (core_release[g] && $past(core_release[g])) |-> $stable(core_entry[g*DATA_W +: DATA_W]));
  end

endmodule

bind boot_mailbox boot_mailbox_chk #(
  .NUM_CORES (NUM_CORES),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .bus_addr     (bus_addr),
  .bus_we       (bus_we),
  .core_reset   (core_reset),
  .wake_evt     (wake_evt),
  .core_release (core_release),
  .core_entry   (core_entry)
);

// File: tb/boot_mailbox_tb_top.sv
`timescale 1ns/1ps
module boot_mailbox_tb_top;

  localparam int NC = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [6:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_rdata;
  logic [NC-1:0] core_reset = '0;
  logic          wake_evt;
  logic [NC-1:0] core_release;
  logic [NC*32-1:0] core_entry;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [31:0] m_fld [4];
  logic        m_rel [NC];
  logic [31:0] m_start [NC];

  always #2 clk = ~clk;

  boot_mailbox dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .core_reset(core_reset),
    .wake_evt(wake_evt), .core_release(core_release), .core_entry(core_entry)
  );

  function automatic logic [31:0] exp_go(input int i);
    return 32'hABBAAB00 | 32'((i + 1) & 8'hFF);
  endfunction

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    chk32(req, 32'(act), 32'(exp));
  endtask

  task automatic check_cores(input string req);
    for (int i = 0; i < NC; i++) begin
      chk1(req, core_release[i], m_rel[i]);
      chk32("R7", core_entry[i*32 +: 32], m_start[i]);
    end
  endtask

  task automatic model_go_update();
    for (int i = 0; i < NC; i++) begin
      logic nxt;
      nxt = (m_fld[1] == exp_go(i));
      if (nxt && !m_rel[i]) m_start[i] = m_fld[0];
      m_rel[i] = nxt;
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
    chk1(a < 7'h10 ? "R4" : "R3", wake_evt, a[6:2] == 5'd1);
    if (a < 7'h10) m_fld[a[3:2]] = d;
    if (a[6:2] == 5'd1) model_go_update();
    @(posedge clk); @(negedge clk);
    chk1("R4", wake_evt, 1'b0);
    check_cores("R5 R6");
  endtask

  task automatic do_read(input logic [6:0] a);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk); @(negedge clk);
    if (a < 7'h10) chk32("R2", bus_rdata, m_fld[a[3:2]]);
    else           chk32("R3", bus_rdata, 32'h0);
  endtask

  task automatic do_core_reset(input int idx, input logic with_wr, input logic [31:0] d);
    core_reset = '0;
    core_reset[idx] = 1'b1;
    if (with_wr) begin bus_addr = 7'h04; bus_wdata = d; bus_we = 1'b1; end
    @(posedge clk); @(negedge clk);
    core_reset = '0; bus_we = 1'b0;
    chk1("R8", wake_evt, with_wr);
    m_fld[1] = 32'h0;
    @(posedge clk); @(negedge clk);
    for (int i = 0; i < NC; i++) m_rel[i] = 1'b0;
    check_cores("R8");
    bus_addr = 7'h04;
    @(posedge clk); @(negedge clk);
    chk32("R8", bus_rdata, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    for (int k = 0; k < 4; k++) m_fld[k] = '0;
    for (int i = 0; i < NC; i++) begin m_rel[i] = 1'b0; m_start[i] = '0; end
    seed_dummy = $urandom(32'd2024);

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    chk1("R1", wake_evt, 1'b0);
    check_cores("R1");
    chk32("R1", bus_rdata, 32'h0);
    for (int k = 0; k < 4; k++) do_read(7'(k * 4));

    // R2 fields and ignored low address bits
    do_write(7'h00, 32'h8000_1000);
    do_write(7'h08, 32'h0000_00A5);
    do_write(7'h0F, 32'hC0DE_F00D);
    do_read(7'h02); do_read(7'h09); do_read(7'h0C);

    // R3 window beyond the fields
    do_write(7'h10, 32'hFFFF_FFFF);
    do_write(7'h7C, 32'h1234_5678);
    do_read(7'h10); do_read(7'h7C); do_read(7'h40);
    do_read(7'h00);

    // R5 no core for bare magic, then core index 1
    do_write(7'h04, 32'hABBAAB00);
    do_write(7'h04, 32'hABBAAB12);
    do_write(7'h04, exp_go(1));
    do_read(7'h05);
    // R7 start address held after later entry writes
    do_write(7'h00, 32'h9000_2000);
    // R6 repeated matching write keeps release; then switch cores
    do_write(7'h04, exp_go(1));
    do_write(7'h04, exp_go(0));
    do_write(7'h04, 32'h0);

    // R8 core reset, alone and against a matching go write
    do_write(7'h04, exp_go(2));
    do_core_reset(0, 1'b0, 32'h0);
    do_core_reset(2, 1'b1, exp_go(2));

    // constrained random
    for (int it = 0; it < 400; it++) begin
      int unsigned op;
      logic [6:0]  a;
      logic [31:0] d;
      op = $urandom % 10;
      a = 7'($urandom % 128);
      if ($urandom % 2) a = {3'b000, 2'($urandom), 2'($urandom)};
      d = $urandom;
      if (op < 5) begin
        if (a[6:2] == 5'd1 && ($urandom % 2)) d = exp_go(int'($urandom % NC));
        do_write(a, d);
      end else if (op < 9) begin
        do_read(a);
      end else begin
        do_core_reset(int'($urandom % NC), 1'($urandom), exp_go(int'($urandom % NC)));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule